// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block watches two clocks, bank A and bank C, that are both divided down from one fast source clock by known integer ratios. It drives an active-low, registered warning signal that goes low for exactly one period of the faster of the two clocks. That low pulse ends at the source-clock cycle where both divided clocks next rise together. The ratios do not have to be integer multiples of each other. The pattern repeats every least common multiple of the two ratios.

The block runs entirely in the source-clock domain and counts in source cycles. The divider block supplies the two ratios. Phase zero of both divided clocks is the first source cycle after reset is released, or the first source cycle after a ratio change. A freeze input holds the output inactive without disturbing the internal timing. This keeps the output aligned when the freeze is lifted.

Top module: `coinc_sync_gen`

## Requirements
- R1: Each low pulse on `syncN` lasts exactly `f` source cycles, where `f` is the smaller of the two effective ratios (one period of the faster clock).
- R2: Counting source cycles `t` from phase zero, `syncN` is low exactly when `t mod P >= P - f`. It is high on the coincident cycles `t mod P == 0`.
- R3: The interval `P` is the least common multiple of the fast ratio and the slow period, for every ratio pair, including pairs that are not integer multiples (for example 3:2, 4:3, 15:14).
- R4: When both ratios are equal to `r`, every edge is shared. The slow period is then taken as `2r`, so `syncN` is low for one period of `r` cycles and high for the next, alternating.
- R5: A ratio input of 0 is treated as a ratio of 1.
- R6: While `syncEn` is 0, `syncN` is high in the following cycle. The phase keeps advancing, so when `syncEn` returns to 1 the output follows the R2 pattern for the current `t`.
- R7: A value of `ratioA` or `ratioC` that differs from the previous cycle restarts the phase. The cycle after the clock edge that samples the new value is phase zero, and `syncN` is high in it.
- R8: Reset (`rstN` low, synchronous) holds `syncN` high. The first cycle after the edge that samples `rstN` high is phase 1, counted from the last reset cycle as phase zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock from which both monitored clocks are divided |
| rstN | input | 1 | Synchronous active-low reset |
| ratioA | input | RATIO_W | Divide ratio of bank A (0 is taken as 1) |
| ratioC | input | RATIO_W | Divide ratio of bank C (0 is taken as 1) |
| syncEn | input | 1 | 1 lets pulses out; 0 freezes the output high |
| syncN | output | 1 | Registered active-low warning pulse before each shared rising edge |

## Verification
Every result appears one source cycle after the edge that samples its cause. A ratio change, a reset level or a change of `syncEn` is seen in `syncN` right after that edge, and the phase count starts there. The bench drives inputs on the falling edge. It advances its own phase count at the rising edge using the inputs it has just sampled, and it compares `syncN` at the next falling edge. Each cycle is therefore judged against the expected window membership for that exact phase, with no slack in either direction.

// File: rtl/coinc_sync_pkg.sv
package coinc_sync_pkg;
  // Strobes from the phase tracker to the output datapath
  typedef struct packed {
    logic restart;  // phase returns to zero at this edge
    logic hit;      // the shared edge lies exactly fast-ratio cycles ahead
  } syncStrobes_t;
endpackage

// File: rtl/coinc_sync_ctrl.sv
module coinc_sync_ctrl
  import coinc_sync_pkg::*;
#(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioA,
  input  logic [RATIO_W-1:0] ratioC,
  output syncStrobes_t       strobes,
  output logic [RATIO_W-1:0] fastRatio
);
  localparam int SLOW_W = RATIO_W + 1;
  localparam logic [RATIO_W-1:0] ONE_F = 1;
  localparam logic [SLOW_W-1:0]  ONE_S = 1;

  logic [RATIO_W-1:0] effA, effC, prevA, prevC;
  logic [RATIO_W-1:0] fastPh, fastNext;
  logic [SLOW_W-1:0]  slowPer, slowPh, slowNext;
  logic               changed, restart;

  // Zero ratio is taken as one
  assign effA = (ratioA == '0) ? ONE_F : ratioA;
  assign effC = (ratioC == '0) ? ONE_F : ratioC;

  assign changed = (effA != prevA) || (effC != prevC);
  assign restart = !rstN || changed;

  // Fast ratio is the smaller one; equal ratios double the slow period
  always_comb begin
    if (effA == effC) begin
      fastRatio = effA;
      slowPer   = {effA, 1'b0};
    end else if (effA < effC) begin
      fastRatio = effA;
      slowPer   = {1'b0, effC};
    end else begin
      fastRatio = effC;
      slowPer   = {1'b0, effA};
    end
  end

  // Lead phases run fastRatio cycles ahead of the real phase
  assign fastNext = (fastPh == fastRatio - ONE_F) ? '0 : fastPh + ONE_F;
  assign slowNext = (slowPh == slowPer - ONE_S)   ? '0 : slowPh + ONE_S;

  always_ff @(posedge clk) begin
    if (restart) begin
      prevA  <= effA;
      prevC  <= effC;
      fastPh <= '0;
      slowPh <= {1'b0, fastRatio};
    end else begin
      fastPh <= fastNext;
      slowPh <= slowNext;
    end
  end

  assign strobes.restart = restart;
  assign strobes.hit     = !restart && (fastNext == '0) && (slowNext == '0);

  // R1: fast lead phase stays inside one fast period
  a_r1_fast_in_range: assert property (@(posedge clk) disable iff (!rstN)
    !changed |-> (fastPh < fastRatio));
  // R3: slow lead phase stays inside one slow period
  a_r3_slow_in_range: assert property (@(posedge clk) disable iff (!rstN)
    !changed |-> (slowPh < slowPer));
endmodule

// File: rtl/coinc_sync_dp.sv
module coinc_sync_dp
  import coinc_sync_pkg::*;
#(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  syncStrobes_t       strobes,
  input  logic [RATIO_W-1:0] fastRatio,
  input  logic               syncEn,
  output logic               syncN
);
  localparam logic [RATIO_W-1:0] ONE_F = 1;

  logic [RATIO_W-1:0] lowLeft;  // low cycles still to come after this one

  always_ff @(posedge clk) begin
    if (strobes.restart) begin
      lowLeft <= '0;
      syncN   <= 1'b1;
    end else if (strobes.hit) begin
      lowLeft <= fastRatio - ONE_F;
      syncN   <= !syncEn;
    end else if (lowLeft != '0) begin
      lowLeft <= lowLeft - ONE_F;
      syncN   <= !syncEn;
    end else begin
      syncN   <= 1'b1;
    end
  end

  // R1: remaining window never exceeds one fast period
  a_r1_window_bounded: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.restart |-> (lowLeft < fastRatio));
  // R2: a detected shared edge opens the low window
  a_r2_hit_drives_low: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.hit && syncEn) |=> !syncN);
  // R6: frozen output stays inactive
  a_r6_frozen_high: assert property (@(posedge clk) disable iff (!rstN)
    !syncEn |=> syncN);
  // R7: ratio change restarts with output inactive
  a_r7_restart_high: assert property (@(posedge clk) disable iff (!rstN)
    strobes.restart |=> syncN);
  // R8: output inactive on leaving reset
  a_r8_release_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> syncN);
endmodule

// File: rtl/coinc_sync_gen.sv
module coinc_sync_gen
  import coinc_sync_pkg::*;
#(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RATIO_W-1:0] ratioA,
  input  logic [RATIO_W-1:0] ratioC,
  input  logic               syncEn,
  output logic               syncN
);
  syncStrobes_t       strobes;
  logic [RATIO_W-1:0] fastRatio;

  coinc_sync_ctrl #(.RATIO_W(RATIO_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .ratioA    (ratioA),
    .ratioC    (ratioC),
    .strobes   (strobes),
    .fastRatio (fastRatio)
  );

  coinc_sync_dp #(.RATIO_W(RATIO_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .fastRatio (fastRatio),
    .syncEn    (syncEn),
    .syncN     (syncN)
  );
endmodule

// File: tb/tb_coinc_sync_gen.sv
module tb_coinc_sync_gen;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN;
  logic [W-1:0] ratioA, ratioC;
  logic         syncEn;
  logic         syncN;

  int checks = 0;
  int errors = 0;
  int mT = 0, mPrevA = 0, mPrevC = 0;
  bit expN;

  always #2 clk = ~clk;  // 250 MHz

  coinc_sync_gen #(.RATIO_W(W)) dut (
    .clk(clk), .rstN(rstN), .ratioA(ratioA), .ratioC(ratioC),
    .syncEn(syncEn), .syncN(syncN)
  );

  function automatic int clampR(int r);
    return (r == 0) ? 1 : r;
  endfunction

  function automatic int lcmF(int x, int y);
    for (int m = x; m <= x * y; m += x)
      if (m % y == 0) return m;
    return x * y;
  endfunction

  function automatic int periodOf(int a, int c);
    int f, s;
    f = (a < c) ? a : c;
    s = (a == c) ? 2 * a : ((a > c) ? a : c);
    return lcmF(f, s);
  endfunction

  function automatic bit inWindow(int a, int c, int t);
    int f, p;
    f = (a < c) ? a : c;
    p = periodOf(a, c);
    return (t % p) >= (p - f);
  endfunction

  task automatic step(string tag);
    int ea, ec;
    @(posedge clk);
    ea = clampR(int'(ratioA));
    ec = clampR(int'(ratioC));
    if (!rstN || ea != mPrevA || ec != mPrevC) begin
      mT = 0; mPrevA = ea; mPrevC = ec;
    end else begin
      mT++;
    end
    expN = !rstN ? 1'b1 : (syncEn ? !inWindow(ea, ec, mT) : 1'b1);
    @(negedge clk);
    checks++;
    if (syncN !== expN) begin
      errors++;
      $display("FAIL %s: ratios %0d:%0d phase %0d syncN actual=%b expected=%b",
               tag, ea, ec, mT, syncN, expN);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=run end before 150000 cycles");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; ratioA = 4'd1; ratioC = 4'd1; syncEn = 1'b1;
    @(negedge clk);
    repeat (3) step("R8 reset holds high");
    rstN = 1'b1;
    repeat (6) step("R8 release phase");

    // Sweep every pair up to 8:8 over two full intervals
    for (int a = 1; a <= 8; a++) begin
      for (int c = 1; c <= 8; c++) begin
        ratioA = W'(a); ratioC = W'(c);
        repeat (2 * periodOf(a, c) + 3)
          step((a == c) ? "R4 equal ratios" : "R1 R2 R3 sweep");
      end
    end

    // Largest non-multiple pair
    ratioA = 4'd15; ratioC = 4'd14;
    repeat (2 * periodOf(15, 14) + 2) step("R3 wide pair");

    // Zero ratios
    ratioA = 4'd0; ratioC = 4'd3;
    repeat (10) step("R5 zero on A");
    ratioA = 4'd2; ratioC = 4'd0;
    repeat (8) step("R5 zero on C");
    ratioA = 4'd0; ratioC = 4'd0;
    repeat (6) step("R5 both zero");

    // Freeze across a window, then resume in phase
    ratioA = 4'd4; ratioC = 4'd3;
    repeat (5) step("R6 before freeze");
    syncEn = 1'b0;
    repeat (14) step("R6 frozen");
    syncEn = 1'b1;
    repeat (20) step("R6 resumed");
    syncEn = 1'b0;
    repeat (3) step("R6 frozen mid window");
    syncEn = 1'b1;
    repeat (12) step("R6 resumed mid window");

    // Ratio changes restart the phase
    ratioA = 4'd6; ratioC = 4'd4;
    repeat (9) step("R7 before change");
    ratioA = 4'd5; ratioC = 4'd2;
    repeat (25) step("R7 after change");
    ratioC = 4'd3;
    repeat (13) step("R7 change inside window");
    ratioA = 4'd2;
    repeat (3) step("R7 quick change");
    ratioA = 4'd3;
    repeat (15) step("R7 settled");

    // Reset in the middle of a run
    rstN = 1'b0;
    repeat (2) step("R8 mid-run reset");
    rstN = 1'b1;
    repeat (12) step("R8 after mid-run reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule